// File: doc/BRIEF.md
# Configuration Port Reboot Sequencer

This block asks an FPGA to reload its bitstream from a chosen flash location. It does this by writing a fixed script of configuration bytes into the device's byte-wide internal configuration port. A single-cycle start pulse latches a 24-bit flash start address and a choice of flash read opcode. The block then sends twenty bytes, one per accepted handshake cycle: two padding bytes, the sync word, two one-word general register writes that carry the address and the opcode, a reboot command write, and two no-operation words.

The port expects every byte with its bit order reversed end-for-end, so the block reverses each byte just before the output. Each 16-bit configuration word goes out as two bytes, high byte first. The downstream port can stall the stream at any time with its ready input. The block reports busy while the script is in flight and gives a one-cycle done pulse once the final byte has been taken.

Top module: `cfg_reboot_seq`

## Requirements
- R1: While reset is high and after it is released with no start, port_valid_o, busy_o and done_o are all low.
- R2: Every byte on port_data_o is bit-reversed: port bit k carries bit 7-k of the logical script byte.
- R3: Logical bytes 0 to 3 of the script are 0xFF, 0xFF, 0xAA, 0x99.
- R4: Logical bytes 4 to 7 are 0x32, 0x61, address bits 15..8, address bits 7..0.
- R5: Logical bytes 8 to 11 are 0x32, 0x81, the flash read opcode, address bits 23..16.
- R6: The opcode is 0x0B when legacy_read_i is low at the accepted start, and 0x03 when it is high.
- R7: Logical bytes 12 to 15 are 0x30, 0xA1, 0x00, 0x0E.
- R8: Logical bytes 16 to 19 are 0x20, 0x00, 0x20, 0x00, and exactly 20 bytes are handed over per request.
- R9: The byte index advances only on cycles with port_valid_o and port_ready_i both high; while valid is high and ready is low, port_data_o holds its value.
- R10: A start pulse while busy is ignored: the address and opcode in flight do not change and the script does not restart.
- R11: busy_o and port_valid_o go high in the cycle after an accepted start; done_o is high for exactly one cycle, the cycle after the last byte is accepted, and busy_o is low in that cycle.
- R12: A start in any idle cycle, including the cycle in which done_o is high, begins a new script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Reboot request pulse |
| flash_addr_i | input | 24 | Flash start address of the image to load |
| legacy_read_i | input | 1 | Select the legacy read opcode instead of fast read |
| port_data_o | output | 8 | Bit-reversed byte to the configuration port |
| port_valid_o | output | 1 | Byte on port_data_o is valid |
| port_ready_i | input | 1 | Configuration port takes the byte this cycle |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
A walking one runs across all 24 address bits, so a bit that lands in the wrong payload slot or is left unreversed shows up in exactly one byte. All-zero, all-one and mixed addresses are also used. Both opcode selections alternate over the sweep. Each is paired with a ready that stays high, a ready that toggles, and a ready driven by a bench shift register, which separates advancing on handshake from advancing on valid alone. Some runs inject a start with a different address mid-script, and one run starts in the same cycle as the previous done, which shows whether a busy start is rejected while an idle start is taken.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 24;
    localparam int SEQ_LEN = 20;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    localparam logic [BYTE_W-1:0] OP_FAST_READ   = 8'h0B;
    localparam logic [BYTE_W-1:0] OP_LEGACY_READ = 8'h03;

    // Configuration packet constants (logical, before bit reversal)
    localparam logic [BYTE_W-1:0] PAD_BYTE     = 8'hFF;
    localparam logic [BYTE_W-1:0] SYNC_HI      = 8'hAA;
    localparam logic [BYTE_W-1:0] SYNC_LO      = 8'h99;
    localparam logic [BYTE_W-1:0] HDR_WR_HI    = 8'h32;
    localparam logic [BYTE_W-1:0] HDR_GPR1_LO  = 8'h61;
    localparam logic [BYTE_W-1:0] HDR_GPR2_LO  = 8'h81;
    localparam logic [BYTE_W-1:0] HDR_CMD_HI   = 8'h30;
    localparam logic [BYTE_W-1:0] HDR_CMD_LO   = 8'hA1;
    localparam logic [BYTE_W-1:0] CMD_RELOAD_H = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_RELOAD_L = 8'h0E;
    localparam logic [BYTE_W-1:0] NOOP_HI      = 8'h20;
    localparam logic [BYTE_W-1:0] NOOP_LO      = 8'h00;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] opcode;
    } reboot_req_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

endpackage

// File: rtl/cfgrb_bitrev.sv
module cfgrb_bitrev #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_swap
        assign dout[g] = din[WIDTH-1-g];
    end
endmodule

// File: rtl/cfgrb_script.sv
module cfgrb_script
    import cfgrb_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  reboot_req_t       req,
    output logic [BYTE_W-1:0] byte_o
);
    always_comb begin
        unique case (idx)
            5'd0, 5'd1: byte_o = PAD_BYTE;
            5'd2:       byte_o = SYNC_HI;
            5'd3:       byte_o = SYNC_LO;
            5'd4:       byte_o = HDR_WR_HI;
            5'd5:       byte_o = HDR_GPR1_LO;
            5'd6:       byte_o = req.addr[15:8];
            5'd7:       byte_o = req.addr[7:0];
            5'd8:       byte_o = HDR_WR_HI;
            5'd9:       byte_o = HDR_GPR2_LO;
            5'd10:      byte_o = req.opcode;
            5'd11:      byte_o = req.addr[23:16];
            5'd12:      byte_o = HDR_CMD_HI;
            5'd13:      byte_o = HDR_CMD_LO;
            5'd14:      byte_o = CMD_RELOAD_H;
            5'd15:      byte_o = CMD_RELOAD_L;
            5'd16:      byte_o = NOOP_HI;
            5'd17:      byte_o = NOOP_LO;
            5'd18:      byte_o = NOOP_HI;
            5'd19:      byte_o = NOOP_LO;
            default:    byte_o = NOOP_LO;
        endcase
    end
endmodule

// File: rtl/cfgrb_ctrl.sv
module cfgrb_ctrl
    import cfgrb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             accept_o,
    output logic [IDX_W-1:0] idx_o
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             xfer;
    logic             at_last;

    assign xfer     = (state_q == ST_SEND) && ready_i;
    assign at_last  = (idx_q == LAST_IDX);
    assign accept_o = (state_q == ST_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= xfer && at_last;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                    end
                end
                ST_SEND: begin
                    if (xfer) begin
                        if (at_last) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign valid_o = (state_q == ST_SEND);
    assign busy_o  = (state_q == ST_SEND);
    assign done_o  = done_q;
    assign idx_o   = idx_q;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX); // R8

    AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(idx_q))); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(valid_o && ready_i))); // R11

    AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !ready_i) |=> (busy_o && $stable(idx_q))); // R10

endmodule

// File: rtl/cfg_reboot_seq.sv
module cfg_reboot_seq
    import cfgrb_pkg::*;
#(
    parameter logic [7:0] FAST_OPCODE   = OP_FAST_READ,
    parameter logic [7:0] LEGACY_OPCODE = OP_LEGACY_READ
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [23:0] flash_addr_i,
    input  logic        legacy_read_i,
    output logic [7:0]  port_data_o,
    output logic        port_valid_o,
    input  logic        port_ready_i,
    output logic        busy_o,
    output logic        done_o
);
    reboot_req_t       req_q;
    logic              accept;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] logical_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.addr   <= flash_addr_i;
            req_q.opcode <= legacy_read_i ? LEGACY_OPCODE : FAST_OPCODE;
        end
    end

    cfgrb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .ready_i  (port_ready_i),
        .valid_o  (port_valid_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .accept_o (accept),
        .idx_o    (idx)
    );

    cfgrb_script u_script (
        .idx    (idx),
        .req    (req_q),
        .byte_o (logical_byte)
    );

    cfgrb_bitrev #(.WIDTH(BYTE_W)) u_rev (
        .din  (logical_byte),
        .dout (port_data_o)
    );

    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(req_q)); // R10

    AST_DATA_HELD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (port_valid_o && !port_ready_i) |=> $stable(port_data_o)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !port_valid_o); // R1

endmodule

// File: tb/tb_cfg_reboot_seq.sv
`timescale 1ns/1ps
module tb_cfg_reboot_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] flash_addr_i = '0;
    logic        legacy_read_i = 1'b0;
    logic [7:0]  port_data_o;
    logic        port_valid_o;
    logic        port_ready_i = 1'b1;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_b [20];
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    cfg_reboot_seq dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .flash_addr_i  (flash_addr_i),
        .legacy_read_i (legacy_read_i),
        .port_data_o   (port_data_o),
        .port_valid_o  (port_valid_o),
        .port_ready_i  (port_ready_i),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    function automatic string tag_of(input int i);
        if (i < 4)       return "R3";
        else if (i < 8)  return "R4";
        else if (i == 10) return "R6";
        else if (i < 12) return "R5";
        else if (i < 16) return "R7";
        else             return "R8";
    endfunction

    task automatic build(input logic [23:0] a, input bit leg);
        exp_b[0]  = 8'hFF; exp_b[1]  = 8'hFF; exp_b[2]  = 8'hAA; exp_b[3]  = 8'h99;
        exp_b[4]  = 8'h32; exp_b[5]  = 8'h61; exp_b[6]  = a[15:8]; exp_b[7] = a[7:0];
        exp_b[8]  = 8'h32; exp_b[9]  = 8'h81;
        exp_b[10] = leg ? 8'h03 : 8'h0B;
        exp_b[11] = a[23:16];
        exp_b[12] = 8'h30; exp_b[13] = 8'hA1; exp_b[14] = 8'h00; exp_b[15] = 8'h0E;
        exp_b[16] = 8'h20; exp_b[17] = 8'h00; exp_b[18] = 8'h20; exp_b[19] = 8'h00;
    endtask

    task automatic run_seq(input logic [23:0] a, input bit leg, input int mode,
                           input bit inject, input bit chained);
        int  got = 0;
        int  cyc = 0;
        bit  seen_done = 0;
        bit  injected = 0;
        bit  prev_stall = 0;
        logic [7:0] prev_data = '0;
        if (!chained) @(negedge clk);
        start_i = 1'b1;
        flash_addr_i = a;
        legacy_read_i = leg;
        build(a, leg);
        @(negedge clk);
        start_i = 1'b0;
        flash_addr_i = ~a;
        legacy_read_i = ~leg;
        chk(busy_o && port_valid_o, chained ? "R12" : "R11", "busy after start",
            {30'd0, busy_o, port_valid_o}, 32'h3);
        chk(!done_o, "R11", "done pulse width", {31'd0, done_o}, 32'h0);
        while (!seen_done && cyc < 400) begin
            if (done_o) begin
                chk(got == 20, "R8", "bytes per request", got, 20);
                chk(!busy_o, "R11", "busy low with done", {31'd0, busy_o}, 32'h0);
                seen_done = 1;
            end else begin
                if (prev_stall)
                    chk(port_data_o == prev_data, "R9", "data held on stall",
                        port_data_o, prev_data);
                case (mode)
                    0: port_ready_i = 1'b1;
                    1: port_ready_i = cyc[0];
                    default: begin
                        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                        port_ready_i = lfsr[0] | lfsr[1];
                    end
                endcase
                if (inject && !injected && got == 7) begin
                    start_i = 1'b1;
                    flash_addr_i = a ^ 24'h5A5A5A;
                    legacy_read_i = ~leg;
                    injected = 1;
                end else begin
                    start_i = 1'b0;
                end
                if (port_valid_o && port_ready_i) begin
                    if (got >= 20) begin
                        chk(0, "R8", "extra byte", port_data_o, 0);
                    end else begin
                        // R2: port carries the reversed logical byte
                        chk(port_data_o == flip(exp_b[got]),
                            inject ? "R10" : tag_of(got), "byte (R2 reversed)",
                            port_data_o, flip(exp_b[got]));
                    end
                    got++;
                end
                prev_stall = port_valid_o && !port_ready_i;
                prev_data  = port_data_o;
                cyc++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        port_ready_i = 1'b1;
        if (!seen_done) chk(0, "R11", "done never seen", 0, 1);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(!done_o && !busy_o && !port_valid_o, "R11", "idle after done",
            {29'd0, done_o, busy_o, port_valid_o}, 32'h0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=expired expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!port_valid_o && !busy_o && !done_o, "R1", "in reset",
            {29'd0, port_valid_o, busy_o, done_o}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!port_valid_o && !busy_o && !done_o, "R1", "after reset",
            {29'd0, port_valid_o, busy_o, done_o}, 32'h0);

        for (int i = 0; i < 24; i++) begin
            run_seq(24'h1 << i, i[0], i % 3, (i % 4) == 1, 1'b0);
            idle_check();
        end
        run_seq(24'h000000, 1'b0, 0, 1'b0, 1'b0); idle_check();
        run_seq(24'hFFFFFF, 1'b1, 1, 1'b1, 1'b0); idle_check();
        run_seq(24'hA5C3F0, 1'b0, 2, 1'b1, 1'b0); idle_check();
        // R12: second request launched in the done cycle of the first
        run_seq(24'h123456, 1'b1, 2, 1'b0, 1'b0);
        run_seq(24'h654321, 1'b0, 0, 1'b0, 1'b1);
        idle_check();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule